// File: doc/BRIEF.md
# Split-Mode Dual 8-bit Capture Timer

The block is a timer peripheral that works as two independent 8-bit counters, a low half and a high half. Each half counts up freely and wraps from 0xFF to 0x00. Each half advances on the ticks of a source it picks for itself from four options: every clock, the clock divided by twelve, a fast tick strobe, or a slow pulse strobe. A single external capture input is shared by both halves. When it rises, each half copies its present count into its own capture register, and both interrupt flags are set in the same cycle.

Software reaches the block through a small register port. Writes take effect at the clock edge. Reads are combinational from the address. The block carries no data stream, so it has no valid/ready interface and no back-pressure. Every pin is a plain control or status signal. A half whose run bit is cleared keeps its count frozen, but it still captures that frozen value and raises its flag on a capture event. Capture events act only when the split control and both capture controls are set.

Register map (addresses on `reg_addr`):
- 0, control: bit0 split, bit1 low capture, bit2 high capture, bit3 low run, bit4 high run, bit5 low interrupt enable, bit6 high interrupt enable, bit7 reads 0.
- 1, tick select: bits[1:0] low half, bits[3:2] high half. The codes are 0 every clock, 1 clock/12, 2 fast tick, 3 slow pulse. Bits[7:4] read 0.
- 2 and 3: low and high counters, read/write.
- 4 and 5: low and high capture registers, read-only.
- 6, flags: bit0 low flag, bit1 high flag. Writing 0 to a bit clears that flag, and writing 1 leaves it unchanged.

Top module: `tmr_split_capture`

## Requirements
- R1: After reset every register reads 0 and `irq`, `flag_lo` and `flag_hi` are 0.
- R2: A capture event acts only while control bits 0, 1 and 2 are all 1. Otherwise a rising capture input changes neither capture register nor any flag.
- R3: `capture_in` passes through two synchronizer flops, and only a 0-to-1 transition makes one capture event. The capture register and flags change on the third rising clock edge after the input rises. An input held high gives no further events.
- R4: A half's counter increases by 1 only in a cycle where its run bit is 1 and its selected tick is asserted (tick select code 0 every clock, 1 one cycle in twelve, 2 `tick_fast`, 3 `tick_slow`). Each half uses only its own select and run bits.
- R5: Each counter wraps from 0xFF to 0x00.
- R6: On a capture event each half loads its capture register with the count it held in that cycle, and both flags become 1 at the same edge.
- R7: A half whose run bit is 0 still captures its frozen count and sets its flag on a capture event.
- R8: Flags stay set until cleared by writing 0 to their bit at address 6. Writing 1 has no effect. A capture event in the same cycle as a clear leaves the flag set.
- R9: `irq` = (low flag AND control bit5) OR (high flag AND control bit6).
- R10: A counter write in the same cycle as a capture event loads the counter with the written value, and the capture register receives the count held before the write.
- R11: The control register and the tick select register read back the values written to them, with the unused bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| tick_fast | input | 1 | Fast tick strobe, one cycle wide |
| tick_slow | input | 1 | Slow pulse strobe, one cycle wide |
| capture_in | input | 1 | Asynchronous capture input |
| flag_lo | output | 1 | Low-half interrupt flag |
| flag_hi | output | 1 | High-half interrupt flag |
| irq | output | 1 | Combined masked interrupt |

## Verification
Register writes land at the clock edge on which the strobe is sampled, so a counter read at the falling edge after N further edges must show the written value plus N ticks. A capture result is due on the third rising edge after `capture_in` rises. The bench raises the input half a cycle before an edge and counts three edges before reading the capture registers and flags. It also reads once before that edge to show that nothing moved early. The two race cases place the flag clear or counter write exactly on that third edge. The clock/12 source is checked over a 24-cycle window, because any such window holds exactly two strobes whatever the prescaler phase.

// File: rtl/tmr_split_pkg.sv
package tmr_split_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 3;
  localparam int unsigned NHALF = 2;
  localparam int unsigned NSRC = 4;

  typedef enum logic [1:0] {
    SRC_CLK   = 2'd0,
    SRC_DIV12 = 2'd1,
    SRC_FAST  = 2'd2,
    SRC_SLOW  = 2'd3
  } tick_src_e;

  typedef enum logic [AW-1:0] {
    A_CTRL   = 3'd0,
    A_TSEL   = 3'd1,
    A_CNT_LO = 3'd2,
    A_CNT_HI = 3'd3,
    A_CAP_LO = 3'd4,
    A_CAP_HI = 3'd5,
    A_FLAGS  = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic       rsv;
    logic [1:0] ie;
    logic [1:0] run;
    logic       cap_hi;
    logic       cap_lo;
    logic       split;
  } ctrl_t;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int unsigned PRESCALE = 12,
  parameter int unsigned NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_fast,
  input  logic            tick_slow,
  output logic [NSRC-1:0] ticks
);
  localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pre_q;
  logic          div_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else if (pre_q == PLAST) pre_q <= '0;
    else pre_q <= pre_q + 1'b1;
  end

  assign div_stb = (pre_q == PLAST);

  always_comb begin
    ticks    = '0;
    ticks[0] = 1'b1;
    ticks[1] = div_stb;
    ticks[2] = tick_fast;
    ticks[3] = tick_slow;
  end

  // R4
  div_strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_stb |=> !div_stb);
endmodule

// File: rtl/tmr_cap_sync.sv
module tmr_cap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;

  // R3
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/tmr_half.sv
module tmr_half #(
  parameter int unsigned DW = 8,
  parameter int unsigned NSRC = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(NSRC)-1:0] sel,
  input  logic                    run,
  input  logic [NSRC-1:0]         ticks,
  input  logic                    cnt_wr,
  input  logic [DW-1:0]           wdata,
  input  logic                    cap_evt,
  input  logic                    flag_clr,
  output logic [DW-1:0]           cnt,
  output logic [DW-1:0]           cap,
  output logic                    flag
);
  logic [DW-1:0] cnt_q;
  logic [DW-1:0] cap_q;
  logic          flag_q;
  logic          adv;

  assign adv = run & ticks[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_wr) cnt_q <= wdata;
    else if (adv) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else if (cap_evt) cap_q <= cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else if (cap_evt) flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign cnt  = cnt_q;
  assign cap  = cap_q;
  assign flag = flag_q;

  // R5
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '1 && adv && !cnt_wr) |=> cnt_q == '0);
  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt_q));
  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> flag_q);
  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);
  // R10
  cap_old_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && cnt_wr) |=> (cap_q == $past(cnt_q) && cnt_q == $past(wdata)));
endmodule

// File: rtl/tmr_split_capture.sv
module tmr_split_capture
  import tmr_split_pkg::*;
#(
  parameter int unsigned PRESCALE = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          tick_fast,
  input  logic          tick_slow,
  input  logic          capture_in,
  output logic          flag_lo,
  output logic          flag_hi,
  output logic          irq
);
  localparam int unsigned SW = $clog2(NSRC);

  ctrl_t               ctrl_q;
  logic [NHALF*SW-1:0] tsel_q;
  logic [NSRC-1:0]     ticks;
  logic                rise;
  logic                cap_mode;
  logic                cap_evt;
  logic [DW-1:0]       cnt  [NHALF];
  logic [DW-1:0]       capv [NHALF];
  logic [NHALF-1:0]    flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tsel_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_CTRL) ctrl_q <= ctrl_t'({1'b0, reg_wdata[DW-2:0]});
      if (reg_addr == A_TSEL) tsel_q <= reg_wdata[NHALF*SW-1:0];
    end
  end

  tmr_tick_gen #(.PRESCALE(PRESCALE), .NSRC(NSRC)) u_ticks (
    .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow),
    .ticks(ticks)
  );

  tmr_cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(capture_in), .rise(rise)
  );

  assign cap_mode = ctrl_q.split & ctrl_q.cap_lo & ctrl_q.cap_hi;
  assign cap_evt  = rise & cap_mode;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic wr_cnt;
    logic clr;
    assign wr_cnt = reg_wr && (reg_addr == AW'(A_CNT_LO + h));
    assign clr    = reg_wr && (reg_addr == A_FLAGS) && !reg_wdata[h];
    tmr_half #(.DW(DW), .NSRC(NSRC)) u_half (
      .clk(clk), .rst_n(rst_n),
      .sel(tsel_q[h*SW +: SW]), .run(ctrl_q.run[h]), .ticks(ticks),
      .cnt_wr(wr_cnt), .wdata(reg_wdata), .cap_evt(cap_evt), .flag_clr(clr),
      .cnt(cnt[h]), .cap(capv[h]), .flag(flags[h])
    );
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:   reg_rdata = ctrl_q;
      A_TSEL:   reg_rdata = DW'(tsel_q);
      A_CNT_LO: reg_rdata = cnt[0];
      A_CNT_HI: reg_rdata = cnt[1];
      A_CAP_LO: reg_rdata = capv[0];
      A_CAP_HI: reg_rdata = capv[1];
      A_FLAGS:  reg_rdata = DW'(flags);
      default:  reg_rdata = '0;
    endcase
  end

  assign flag_lo = flags[0];
  assign flag_hi = flags[1];
  assign irq     = |(flags & ctrl_q.ie);

  // R6
  both_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (flag_lo && flag_hi));
  // R2
  no_capture_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_mode && !(reg_wr && reg_addr == A_FLAGS)) |=> $stable(flags));
  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_lo || flag_hi));
endmodule

// File: tb/test_tmr_split_capture.sv
module test_tmr_split_capture;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tick_fast = 1'b0;
  logic       tick_slow = 1'b0;
  logic       capture_in = 1'b0;
  logic       flag_lo, flag_hi, irq;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [7:0] MODE = 8'h07;
  localparam logic [7:0] RUNLO = 8'h08;
  localparam logic [7:0] RUNHI = 8'h10;

  always #10 clk = ~clk;

  tmr_split_capture i_tmr_split_capture (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_fast(tick_fast),
    .tick_slow(tick_slow), .capture_in(capture_in), .flag_lo(flag_lo),
    .flag_hi(flag_hi), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, input string req, input logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  // called at a falling edge, returns at the next falling edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cap_pulse;
    capture_in = 1'b1;
    cycles(4);
    capture_in = 1'b0;
    cycles(4);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 7; a++) rd(3'(a), "R1 reset register", 8'h00);
    chk("R1 reset irq", {5'b0, irq, flag_hi, flag_lo}, 8'h00);
  endtask

  task automatic t_regs;
    wr(3'd0, 8'hE0);
    rd(3'd0, "R11 control readback", 8'h60);
    wr(3'd1, 8'hFB);
    rd(3'd1, "R11 tick select readback", 8'h0B);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_count_clk;
    wr(3'd0, MODE | RUNLO);
    wr(3'd3, 8'h30);
    wr(3'd2, 8'h10);
    cycles(5);
    rd(3'd2, "R4 every-clock count", 8'h15);
    rd(3'd3, "R4 stopped high half holds", 8'h30);
    wr(3'd2, 8'hFD);
    cycles(5);
    rd(3'd2, "R5 wrap", 8'h02);
  endtask

  task automatic t_div12;
    wr(3'd1, 8'h01);
    wr(3'd2, 8'h00);
    cycles(24);
    rd(3'd2, "R4 clock/12 count", 8'h02);
  endtask

  task automatic t_strobes;
    wr(3'd0, MODE | RUNLO | RUNHI);
    wr(3'd1, 8'h0B);
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h00);
    for (int i = 0; i < 3; i++) begin
      tick_fast = 1'b1; cycles(1); tick_fast = 1'b0; cycles(1);
    end
    tick_slow = 1'b1; cycles(1); tick_slow = 1'b0; cycles(1);
    rd(3'd2, "R4 low half on slow pulse", 8'h01);
    rd(3'd3, "R4 high half on fast tick", 8'h03);
  endtask

  task automatic t_capture_stopped;
    wr(3'd0, MODE);
    wr(3'd2, 8'h21);
    wr(3'd3, 8'h9C);
    wr(3'd6, 8'h00);
    capture_in = 1'b1;
    cycles(2);
    rd(3'd6, "R3 no capture before third edge", 8'h00);
    cycles(1);
    rd(3'd6, "R3 flags on third edge", 8'h03);
    rd(3'd4, "R7 stopped low captures", 8'h21);
    rd(3'd5, "R7 stopped high captures", 8'h9C);
    chk("R6 both flag pins", {6'b0, flag_hi, flag_lo}, 8'h03);
    wr(3'd6, 8'h00);
    cycles(6);
    rd(3'd6, "R3 held input gives one event", 8'h00);
    capture_in = 1'b0;
    cycles(4);
  endtask

  task automatic t_capture_running;
    wr(3'd0, MODE | RUNLO);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h40);
    capture_in = 1'b1;
    cycles(3);
    rd(3'd4, "R6 running capture value", 8'h42);
    rd(3'd2, "R6 counter keeps running", 8'h43);
    capture_in = 1'b0;
    cycles(4);
  endtask

  task automatic t_mode_off;
    wr(3'd0, 8'h03);
    wr(3'd6, 8'h00);
    wr(3'd2, 8'h77);
    wr(3'd3, 8'h88);
    cap_pulse();
    rd(3'd4, "R2 low capture unchanged", 8'h42);
    rd(3'd5, "R2 high capture unchanged", 8'h9C);
    rd(3'd6, "R2 flags stay clear", 8'h00);
  endtask

  task automatic t_flags;
    wr(3'd0, MODE);
    cap_pulse();
    wr(3'd6, 8'h02);
    rd(3'd6, "R8 clear low only", 8'h02);
    wr(3'd6, 8'hFF);
    rd(3'd6, "R8 writing ones no effect", 8'h02);
    wr(3'd6, 8'h00);
    rd(3'd6, "R8 clear all", 8'h00);
    capture_in = 1'b1;
    cycles(2);
    wr(3'd6, 8'h00);
    rd(3'd6, "R8 capture beats clear", 8'h03);
    capture_in = 1'b0;
    cycles(4);
  endtask

  task automatic t_write_race;
    wr(3'd2, 8'h11);
    capture_in = 1'b1;
    cycles(2);
    wr(3'd2, 8'h55);
    rd(3'd4, "R10 capture gets old count", 8'h11);
    rd(3'd2, "R10 counter takes write", 8'h55);
    capture_in = 1'b0;
    cycles(4);
  endtask

  task automatic t_irq;
    wr(3'd0, MODE | 8'h20);
    chk("R9 low enabled, flags set", {7'b0, irq}, 8'h01);
    wr(3'd6, 8'h02);
    chk("R9 only masked high flag", {7'b0, irq}, 8'h00);
    wr(3'd0, MODE | 8'h40);
    chk("R9 high enabled", {7'b0, irq}, 8'h01);
    wr(3'd6, 8'h00);
    chk("R9 no flags", {7'b0, irq}, 8'h00);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    cycles(1);
    t_reset();
    t_regs();
    t_count_clk();
    t_div12();
    t_strobes();
    t_capture_stopped();
    t_capture_running();
    t_mode_off();
    t_flags();
    t_write_race();
    t_irq();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule